// File: doc/BRIEF.md
# Dual-Side FIFO Control Register

This block holds the FIFO control settings of a UART-compatible peripheral that two processors share. The host writes a control byte through a write port. The block decodes five things from that byte: the FIFO enable, the receive trigger level, the DMA mode, and the transmit and receive FIFO reset requests. It drives the matching level and pulse outputs to the FIFO logic around it.

A local processor reads a status byte through its own read port. In that byte, the bit positions that the host treats as reserved carry two sticky interrupt flags. One flag means "the host wrote the control register". The other means "transmit overrun". The status byte also carries sticky shadow copies of the host's reset requests. A single local read clears all of these sticky bits. The local side can also hold FIFO mode off, and this override beats whatever the host last wrote.

Top module: `fifo_ctrl_dual`

## Requirements
- R1: A host write whose bit 0 is 0 leaves the stored trigger code (bits 7:6) and DMA bit (bit 3) unchanged. It produces no FIFO reset pulse from bits 1 or 2.
- R2: When the effective enable changes value, `flush_all_o`, `rx_flush_o` and `tx_flush_o` pulse high for one cycle. This happens in the same cycle that `fifo_en_o` shows the new value. The effective enable is the host enable bit with the local force-off applied.
- R3: A host write with bit 0 = 1 and bit 1 = 1 makes `rx_flush_o` high for exactly the next cycle. With bit 0 = 1 and bit 2 = 1, `tx_flush_o` behaves the same way.
- R4: Each reset request from R3 sets a shadow bit: receive shadow at status bit 1, transmit shadow at status bit 2. The shadow stays set until a local read. If a read and a new request land in the same cycle, the bit stays set.
- R5: Status bit 5 is set by every host write. Status bit 4 is set by a `tx_overrun` pulse. A local read clears both. A set in the same cycle as a read wins over the clear.
- R6: `dma_mode1_o` is high only while the stored DMA bit is 1 and the effective enable is 1. Status bit 3 shows the stored DMA bit.
- R7: `rx_trig_bytes_o` gives the receive trigger level in bytes for the stored code: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Status bits 7:6 show the code.
- R8: While `loc_force_off` is high at a clock edge, `fifo_en_o` is 0 after that edge, whatever the host enable bit is. Status bit 0 shows the effective enable.
- R9: `loc_irq_o` is the OR of status bits 4 and 5. It stays high until a local read clears both.
- R10: After reset:
  - all outputs are 0, except `rx_trig_bytes_o`, which is 1;
  - the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host control byte |
| loc_rd | input | 1 | Local read strobe; clears the sticky status bits at the edge |
| loc_force_off | input | 1 | Local override that holds FIFO mode off |
| tx_overrun | input | 1 | Transmit overrun event pulse |
| loc_rdata | output | 8 | Local status byte |
| fifo_en_o | output | 1 | Effective FIFO enable |
| dma_mode1_o | output | 1 | Multi-byte DMA mode selected |
| rx_trig_bytes_o | output | 4 | Receive trigger level in bytes |
| rx_flush_o | output | 1 | Receive FIFO pointer reset pulse |
| tx_flush_o | output | 1 | Transmit FIFO pointer reset pulse |
| flush_all_o | output | 1 | Flush holding/buffer registers and pending host interrupts |
| loc_irq_o | output | 1 | Local interrupt request |

## Verification
The hardest cases to reach are the ones where several events coincide. A host reset request, a flag set and a local read can fall on the same edge. A host write can also arrive while the local override is holding the enable off, so the toggle detector must see no change even though the host bit flipped.

The bench sweeps all 256 host control bytes in sequence, so the enable bit alternates with every combination of the other bits. It interleaves local reads on a fixed stride, so reads land on the cycles directly after reset requests and the shadows are both refilled and cleared. It then runs directed steps that force the override on and off around writes, and that pulse an overrun on the same cycle as a read.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned TRIG_W   = 2;
  localparam int unsigned LEVEL_W  = 4;
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_RXRST  = 1;
  localparam int unsigned B_TXRST  = 2;
  localparam int unsigned B_DMA    = 3;
  localparam int unsigned B_OVR    = 4;
  localparam int unsigned B_CHG    = 5;
  localparam int unsigned B_TRIG   = 6;

  typedef logic [TRIG_W-1:0] trig_code_t;

  typedef struct packed {
    logic any_wr;
    logic rx_rst;
    logic tx_rst;
  } host_req_t;

  // Trigger code to byte count
  function automatic logic [LEVEL_W-1:0] trig_bytes(input trig_code_t code);
    logic [LEVEL_W-1:0] lvl;
    case (code)
      2'b00:   lvl = LEVEL_W'(1);
      2'b01:   lvl = LEVEL_W'(4);
      2'b10:   lvl = LEVEL_W'(8);
      default: lvl = LEVEL_W'(14);
    endcase
    return lvl;
  endfunction
endpackage

// File: rtl/fctl_host_decode.sv
module fctl_host_decode
  import fctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic              host_en_next,
  output logic              dma_q,
  output trig_code_t        trig_q,
  output host_req_t         req
);
  logic host_en_q;
  logic field_wr;
  logic unused_rsvd;

  // bits 5:4 carry no meaning on the host side
  assign unused_rsvd = ^host_wdata[B_CHG:B_OVR];

  // other fields are programmed only together with the enable bit
  assign field_wr     = host_wr && host_wdata[B_EN];
  assign host_en_next = host_wr ? host_wdata[B_EN] : host_en_q;

  assign req.any_wr = host_wr;
  assign req.rx_rst = field_wr && host_wdata[B_RXRST];
  assign req.tx_rst = field_wr && host_wdata[B_TXRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_en_q <= 1'b0;
      dma_q     <= 1'b0;
      trig_q    <= '0;
    end else begin
      host_en_q <= host_en_next;
      if (field_wr) begin
        dma_q  <= host_wdata[B_DMA];
        trig_q <= host_wdata[B_TRIG +: TRIG_W];
      end
    end
  end

  AST_DISABLED_WRITE_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && !host_wdata[B_EN]) |-> ($stable(trig_q) && $stable(dma_q))); // R1
endmodule

// File: rtl/fctl_enable_track.sv
module fctl_enable_track (
  input  logic clk,
  input  logic rst_n,
  input  logic host_en_next,
  input  logic force_off,
  input  logic rx_req,
  input  logic tx_req,
  output logic fifo_en_o,
  output logic rx_flush_o,
  output logic tx_flush_o,
  output logic flush_all_o
);
  logic eff_next;
  logic toggle;

  assign eff_next = host_en_next && !force_off;
  assign toggle   = eff_next ^ fifo_en_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_o   <= 1'b0;
      rx_flush_o  <= 1'b0;
      tx_flush_o  <= 1'b0;
      flush_all_o <= 1'b0;
    end else begin
      fifo_en_o   <= eff_next;
      flush_all_o <= toggle;
      rx_flush_o  <= rx_req || toggle;
      tx_flush_o  <= tx_req || toggle;
    end
  end

  AST_FLUSH_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_o != $past(fifo_en_o)) |-> (flush_all_o && rx_flush_o && tx_flush_o)); // R2
  AST_FORCE_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_off) |-> !fifo_en_o); // R8
  AST_RX_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush_o && !flush_all_o) |-> $past(rx_req)); // R3
  AST_TX_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_o && !flush_all_o) |-> $past(tx_req)); // R3
endmodule

// File: rtl/fctl_local_status.sv
module fctl_local_status (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_rd,
  input  logic any_wr,
  input  logic rx_req,
  input  logic tx_req,
  input  logic tx_overrun,
  output logic rx_shadow,
  output logic tx_shadow,
  output logic chg_flag,
  output logic ovr_flag,
  output logic loc_irq
);
  // sticky: a set in the read cycle survives the clear
  function automatic logic sticky(input logic cur, input logic set, input logic clr);
    return set || (cur && !clr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_shadow <= 1'b0;
      tx_shadow <= 1'b0;
      chg_flag  <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      rx_shadow <= sticky(rx_shadow, rx_req, loc_rd);
      tx_shadow <= sticky(tx_shadow, tx_req, loc_rd);
      chg_flag  <= sticky(chg_flag, any_wr, loc_rd);
      ovr_flag  <= sticky(ovr_flag, tx_overrun, loc_rd);
    end
  end

  assign loc_irq = chg_flag || ovr_flag;

  AST_RX_SHADOW_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_shadow) |-> $past(loc_rd)); // R4
  AST_TX_SHADOW_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_shadow) |-> $past(loc_rd)); // R4
  AST_OVR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_overrun) |-> ovr_flag); // R5
  AST_IRQ_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_irq) |-> $past(loc_rd)); // R9
endmodule

// File: rtl/fifo_ctrl_dual.sv
module fifo_ctrl_dual
  import fctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [CTRL_W-1:0]  host_wdata,
  input  logic               loc_rd,
  input  logic               loc_force_off,
  input  logic               tx_overrun,
  output logic [CTRL_W-1:0]  loc_rdata,
  output logic               fifo_en_o,
  output logic               dma_mode1_o,
  output logic [LEVEL_W-1:0] rx_trig_bytes_o,
  output logic               rx_flush_o,
  output logic               tx_flush_o,
  output logic               flush_all_o,
  output logic               loc_irq_o
);
  logic       host_en_next;
  logic       dma_q;
  trig_code_t trig_q;
  host_req_t  req;
  logic       rx_shadow, tx_shadow, chg_flag, ovr_flag;

  fctl_host_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .host_en_next (host_en_next),
    .dma_q        (dma_q),
    .trig_q       (trig_q),
    .req          (req)
  );

  fctl_enable_track u_en (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_en_next (host_en_next),
    .force_off    (loc_force_off),
    .rx_req       (req.rx_rst),
    .tx_req       (req.tx_rst),
    .fifo_en_o    (fifo_en_o),
    .rx_flush_o   (rx_flush_o),
    .tx_flush_o   (tx_flush_o),
    .flush_all_o  (flush_all_o)
  );

  fctl_local_status u_loc (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_rd     (loc_rd),
    .any_wr     (req.any_wr),
    .rx_req     (req.rx_rst),
    .tx_req     (req.tx_rst),
    .tx_overrun (tx_overrun),
    .rx_shadow  (rx_shadow),
    .tx_shadow  (tx_shadow),
    .chg_flag   (chg_flag),
    .ovr_flag   (ovr_flag),
    .loc_irq    (loc_irq_o)
  );

  assign dma_mode1_o     = dma_q && fifo_en_o;
  assign rx_trig_bytes_o = trig_bytes(trig_q);

  always_comb begin
    loc_rdata                      = '0;
    loc_rdata[B_EN]                = fifo_en_o;
    loc_rdata[B_RXRST]             = rx_shadow;
    loc_rdata[B_TXRST]             = tx_shadow;
    loc_rdata[B_DMA]               = dma_q;
    loc_rdata[B_OVR]               = ovr_flag;
    loc_rdata[B_CHG]               = chg_flag;
    loc_rdata[B_TRIG +: TRIG_W]    = trig_q;
  end

  AST_TRIG_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_trig_bytes_o == 4'd1) || (rx_trig_bytes_o == 4'd4) ||
    (rx_trig_bytes_o == 4'd8) || (rx_trig_bytes_o == 4'd14)); // R7
  AST_DMA_FOLLOWS_STORED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode1_o |-> loc_rdata[B_DMA]); // R6
endmodule

// File: tb/fifo_ctrl_dual_tb_top.sv
module fifo_ctrl_dual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       loc_rd = 1'b0;
  logic       loc_force_off = 1'b0;
  logic       tx_overrun = 1'b0;
  logic [7:0] loc_rdata;
  logic       fifo_en_o, dma_mode1_o, rx_flush_o, tx_flush_o, flush_all_o, loc_irq_o;
  logic [3:0] rx_trig_bytes_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic       m_hen = 0, m_eff = 0, m_dma = 0, m_shrx = 0, m_shtx = 0, m_chg = 0, m_ovr = 0;
  logic [1:0] m_trig = 0;
  logic       e_rx = 0, e_tx = 0, e_all = 0;

  always #10 clk = ~clk; // 50 MHz

  fifo_ctrl_dual dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .loc_rd(loc_rd), .loc_force_off(loc_force_off), .tx_overrun(tx_overrun),
    .loc_rdata(loc_rdata), .fifo_en_o(fifo_en_o), .dma_mode1_o(dma_mode1_o),
    .rx_trig_bytes_o(rx_trig_bytes_o), .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o),
    .flush_all_o(flush_all_o), .loc_irq_o(loc_irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'd0) ? 1 : 4 * int'(c) + ((c == 2'd3) ? 2 : 0);
  endfunction

  task automatic check_all();
    check("R2 flush_all", int'(flush_all_o), int'(e_all));
    check("R3 rx_flush", int'(rx_flush_o), int'(e_rx));
    check("R3 tx_flush", int'(tx_flush_o), int'(e_tx));
    check("R8 fifo_en", int'(fifo_en_o), int'(m_eff));
    check("R6 dma_mode1", int'(dma_mode1_o), int'(m_dma & m_eff));
    check("R7 trig bytes", int'(rx_trig_bytes_o), lvl(m_trig));
    check("R9 irq", int'(loc_irq_o), int'(m_chg | m_ovr));
    check("R4 R5 status byte", int'(loc_rdata),
          int'({m_trig, m_chg, m_ovr, m_dma, m_shtx, m_shrx, m_eff}));
  endtask

  // drive one cycle of stimulus, update the model, check after the edge
  task automatic step(input logic wr, input logic [7:0] d, input logic rd, input logic ov);
    logic rxr, txr, neff;
    host_wr = wr; host_wdata = d; loc_rd = rd; tx_overrun = ov;
    rxr = wr & d[0] & d[1];
    txr = wr & d[0] & d[2];
    if (wr) begin
      m_hen = d[0];
      if (d[0]) begin m_trig = d[7:6]; m_dma = d[3]; end
    end
    neff   = m_hen & ~loc_force_off;
    e_all  = neff ^ m_eff;
    e_rx   = rxr | e_all;
    e_tx   = txr | e_all;
    m_eff  = neff;
    m_shrx = rxr | (m_shrx & ~rd);
    m_shtx = txr | (m_shtx & ~rd);
    m_chg  = wr  | (m_chg & ~rd);
    m_ovr  = ov  | (m_ovr & ~rd);
    @(negedge clk);
    host_wr = 0; loc_rd = 0; tx_overrun = 0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset status", int'(loc_rdata), 0);
    check("R10 reset trig", int'(rx_trig_bytes_o), 1);
    check("R10 reset outs", int'({fifo_en_o, dma_mode1_o, rx_flush_o, tx_flush_o, flush_all_o, loc_irq_o}), 0);

    // R1 R2 R3 R4 R5: sweep every host byte, reads on a stride
    for (int v = 0; v < 256; v++) begin
      step(1'b1, 8'(v), 1'b0, 1'b0);
      step(1'b0, 8'h00, (v % 3) == 0, 1'b0); // pulses one cycle wide (R3)
    end

    // R8: override drops enable and flushes; host write while forced
    loc_force_off = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 8'hC9, 1'b0, 1'b0);
    step(1'b1, 8'h40, 1'b1, 1'b0);
    step(1'b1, 8'h81, 1'b0, 1'b0);
    loc_force_off = 1'b0;
    step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);

    // R5 R9: overrun on the read cycle survives; next read clears all
    step(1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    // R4: reset request on the read cycle stays set
    step(1'b1, 8'h07, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule